// File: doc/BRIEF.md
# Clock-Enable Driven Rate Decimator

This block lowers the rate of a data stream by an integer factor. Two clock enables drive it: a fast one, `src_ce`, that is high in every cycle carrying an input sample, and a slow one, `dst_ce`, that is raised together with `src_ce` on the final sample of each frame. A frame is RATIO consecutive accepted samples. From each frame the block keeps one sample, either the opening one or the closing one, and holds it on `dout` for a whole output period. It has no counter of its own. Frame position is inferred from the enables alone.

Two parameters select one of three capture structures. With `ZERO_LAT=1`, the opening sample is shown through a bypass multiplexer in the very cycle it arrives. A hold register then keeps it for the rest of the frame. With `ZERO_LAT=0` and `KEEP_LAST=0`, a front register takes the opening sample and a back register copies it at frame end, so the output trails by one frame. With `KEEP_LAST=1`, a single register takes the closing sample at frame end. Asking for zero latency together with the closing sample stops elaboration with an error, and so does a RATIO below 2.

Frame position is held in a one-bit state machine. It has two states, FR_HEAD (the next accepted sample opens a frame) and FR_BODY (the frame is under way). Reset enters FR_HEAD. FR_HEAD moves to FR_BODY on `src_ce` without `dst_ce`. FR_BODY returns to FR_HEAD on `src_ce` together with `dst_ce`. Every other input combination leaves the state unchanged. A separate enable generator, `decim_ce_gen`, produces a legal enable pair from counters for test use.

Top module: `rate_decimator`

## Requirements
- R1: With ZERO_LAT=0 and KEEP_LAST=0, beginning one cycle after the clock edge at which frame k's closing sample is accepted (`src_ce` and `dst_ce` both 1), `dout` equals frame k's opening sample. It keeps that value until the next such edge.
- R2: With KEEP_LAST=1, beginning one cycle after the clock edge at which frame k's closing sample is accepted, `dout` equals that closing sample. It keeps that value until the next such edge.
- R3: With ZERO_LAT=1, in the cycle where a frame's opening sample is accepted, `dout` equals `din` combinationally. From then until the next opening sample, `dout` keeps that value.
- R4: The first `src_ce` cycle after reset opens a frame. So does the first `src_ce` cycle after each cycle with both `src_ce` and `dst_ce`. Every other `src_ce` cycle lies inside a frame.
- R5: `dout` never changes inside a frame. With a nonzero latency it changes only in the cycle after a frame-end edge. With zero latency it changes only in opening-sample cycles.
- R6: A synchronous active-high `rst` clears every data register and returns the frame state to FR_HEAD. After reset, `dout` reads 0 until the first capture.
- R7: `din` in cycles with `src_ce` low is ignored, and `dst_ce` raised without `src_ce` has no effect on the frame state or on `dout`.
- R8: For a fixed `gap` input G, the test generator raises `src_ce` in the first cycle after reset and then once every G+1 cycles. It raises `dst_ce` together with every RATIO-th `src_ce`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_ce | input | 1 | Input-rate enable, one accepted sample per high cycle |
| dst_ce | input | 1 | Output-rate enable, high with `src_ce` on a frame's closing sample |
| din | input | DATA_W | Input sample |
| dout | output | DATA_W | Decimated, held sample |

## Verification
The hardest case to reach from the ports is a frame whose samples are spread over cycles with idle gaps. In that case stale `din` values and a stray `dst_ce` without `src_ce` appear between accepted samples, and none of them may disturb the frame state or the held value. The random phase drops `src_ce` in about 40% of cycles and still changes `din` in every cycle. It also injects lone `dst_ce` pulses. A reset lands in the middle of a frame, and the generator-driven phases cover the back-to-back cadence and a spaced cadence. All three structures run on the same stimulus and are compared with one bench model.

// File: rtl/decim_pkg.sv
package decim_pkg;

    // Frame tracking state: value 0 is the reset state.
    typedef enum logic {
        FR_HEAD = 1'b0,
        FR_BODY = 1'b1
    } frame_st_e;

    // Capture structure picked from the two configuration flags.
    typedef enum logic [1:0] {
        ARCH_BYPASS  = 2'd0,
        ARCH_TWO_REG = 2'd1,
        ARCH_ONE_REG = 2'd2
    } cap_arch_e;

    function automatic cap_arch_e arch_of(input bit zero_lat, input bit keep_last);
        if (keep_last)
            return ARCH_ONE_REG;
        else if (zero_lat)
            return ARCH_BYPASS;
        else
            return ARCH_TWO_REG;
    endfunction

endpackage

// File: rtl/decim_ce_gen.sv
module decim_ce_gen #(
    parameter int unsigned RATIO = 4,
    parameter int unsigned GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GAP_W-1:0] gap,
    output logic             src_ce,
    output logic             dst_ce
);
    localparam int unsigned POS_W = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(RATIO - 1);

    logic [GAP_W-1:0] gap_q;
    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
            pos_q <= '0;
        end else begin
            if (gap_q >= gap)
                gap_q <= '0;
            else
                gap_q <= gap_q + 1'b1;
            if (src_ce)
                pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
        end
    end

    always_comb begin
        src_ce = !rst && (gap_q == '0);
        dst_ce = src_ce && (pos_q == POS_LAST);
    end

endmodule

// File: rtl/decim_frame_fsm.sv
module decim_frame_fsm
    import decim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic src_ce,
    input  logic dst_ce,
    output logic head_ce,
    output logic tail_ce
);
    frame_st_e st_q;
    frame_st_e st_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            st_q <= FR_HEAD;
        else
            st_q <= st_nx;
    end

    // Transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FR_HEAD: if (src_ce && !dst_ce) st_nx = FR_BODY;
            FR_BODY: if (src_ce && dst_ce)  st_nx = FR_HEAD;
        endcase
    end

    // Outputs: start-of-frame strobe and end-of-frame strobe
    always_comb begin
        head_ce = 1'b0;
        tail_ce = src_ce && dst_ce;
        unique case (st_q)
            FR_HEAD: head_ce = src_ce;
            FR_BODY: head_ce = 1'b0;
        endcase
    end

endmodule

// File: rtl/decim_capture.sv
module decim_capture
    import decim_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter cap_arch_e   ARCH   = ARCH_TWO_REG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              head_ce,
    input  logic              tail_ce,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    generate
        case (ARCH)
            ARCH_BYPASS: begin : g_bypass
                logic [DATA_W-1:0] hold_q;
                always_ff @(posedge clk) begin
                    if (rst)
                        hold_q <= '0;
                    else if (head_ce)
                        hold_q <= din;
                end
                assign dout = head_ce ? din : hold_q;
            end
            ARCH_TWO_REG: begin : g_two
                logic [DATA_W-1:0] front_q;
                logic [DATA_W-1:0] back_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        front_q <= '0;
                        back_q  <= '0;
                    end else begin
                        if (head_ce)
                            front_q <= din;
                        if (tail_ce)
                            back_q <= front_q;
                    end
                end
                assign dout = back_q;
            end
            default: begin : g_one
                logic [DATA_W-1:0] last_q;
                always_ff @(posedge clk) begin
                    if (rst)
                        last_q <= '0;
                    else if (tail_ce)
                        last_q <= din;
                end
                assign dout = last_q;
            end
        endcase
    endgenerate

endmodule

// File: rtl/rate_decimator.sv
module rate_decimator
    import decim_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned RATIO     = 4,
    parameter bit          KEEP_LAST = 1'b0,
    parameter bit          ZERO_LAT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_ce,
    input  logic              dst_ce,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam cap_arch_e ARCH = arch_of(ZERO_LAT, KEEP_LAST);

    generate
        if (RATIO < 2) begin : g_bad_ratio
            $error("rate_decimator: RATIO must be at least 2");
        end
        if (ZERO_LAT && KEEP_LAST) begin : g_bad_mode
            $error("rate_decimator: zero latency requires keeping the first sample");
        end
    endgenerate

    logic head_ce;
    logic tail_ce;

    decim_frame_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .src_ce  (src_ce),
        .dst_ce  (dst_ce),
        .head_ce (head_ce),
        .tail_ce (tail_ce)
    );

    decim_capture #(
        .DATA_W (DATA_W),
        .ARCH   (ARCH)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .head_ce (head_ce),
        .tail_ce (tail_ce),
        .din     (din),
        .dout    (dout)
    );

endmodule

// File: rtl/rate_decimator_chk.sv
module rate_decimator_chk #(
    parameter int unsigned DATA_W    = 16,
    parameter bit          KEEP_LAST = 1'b0,
    parameter bit          ZERO_LAT  = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              src_ce,
    input logic              dst_ce,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              head_ce
);
    // R4: an accepted closing sample makes the next accepted sample an opening one
    p_end_head_r4: assert property (@(posedge clk) disable iff (rst)
        (src_ce && dst_ce) |=> (head_ce || !src_ce));

    // R4: an opening sample that does not close the frame is followed by no opening strobe
    p_body_r4: assert property (@(posedge clk) disable iff (rst)
        (head_ce && !dst_ce) |=> !head_ce);

    // R6: the first cycle out of reset shows zero unless a bypassed opening sample is present
    p_reset_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dout == '0 || head_ce));

    generate
        if (ZERO_LAT) begin : g_zl
            // R3: opening sample passes straight through
            p_pass_r3: assert property (@(posedge clk) disable iff (rst)
                head_ce |-> (dout == din));
            // R5: no change outside opening-sample cycles
            p_zl_hold_r5: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && !head_ce) |-> $stable(dout));
        end else begin : g_lat
            // R5: output moves only right after a frame-end edge
            p_hold_r5: assert property (@(posedge clk) disable iff (rst)
                !(src_ce && dst_ce) |=> $stable(dout));
            if (KEEP_LAST) begin : g_last
                // R2: closing sample appears one cycle after its edge
                p_last_r2: assert property (@(posedge clk) disable iff (rst)
                    (src_ce && dst_ce) |=> (dout == $past(din)));
            end else begin : g_first
                // R1: taking the opening sample does not disturb the presented value
                p_pipe_quiet_r1: assert property (@(posedge clk) disable iff (rst)
                    (head_ce && !dst_ce) |=> $stable(dout));
            end
        end
    endgenerate

endmodule

bind rate_decimator rate_decimator_chk #(
    .DATA_W    (DATA_W),
    .KEEP_LAST (KEEP_LAST),
    .ZERO_LAT  (ZERO_LAT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .src_ce  (src_ce),
    .dst_ce  (dst_ce),
    .din     (din),
    .dout    (dout),
    .head_ce (head_ce)
);

// File: tb/tb_rate_decimator.sv
module tb_rate_decimator;
    localparam int unsigned W = 16;
    localparam int unsigned L = 4;
    localparam int unsigned GW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic b_src = 1'b0;
    logic b_dst = 1'b0;
    logic use_gen = 1'b0;
    logic [GW-1:0] gap = '0;
    logic [W-1:0] din = '0;
    logic g_src, g_dst, src_ce, dst_ce;
    logic [W-1:0] d_pipe, d_last, d_zl;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign src_ce = use_gen ? g_src : b_src;
    assign dst_ce = use_gen ? g_dst : b_dst;

    decim_ce_gen #(.RATIO(L), .GAP_W(GW)) u_gen (
        .clk(clk), .rst(rst), .gap(gap), .src_ce(g_src), .dst_ce(g_dst));

    rate_decimator #(.DATA_W(W), .RATIO(L), .KEEP_LAST(1'b0), .ZERO_LAT(1'b0)) dut (
        .clk(clk), .rst(rst), .src_ce(src_ce), .dst_ce(dst_ce), .din(din), .dout(d_pipe));
    rate_decimator #(.DATA_W(W), .RATIO(L), .KEEP_LAST(1'b1), .ZERO_LAT(1'b0)) dut_last (
        .clk(clk), .rst(rst), .src_ce(src_ce), .dst_ce(dst_ce), .din(din), .dout(d_last));
    rate_decimator #(.DATA_W(W), .RATIO(L), .KEEP_LAST(1'b0), .ZERO_LAT(1'b1)) dut_zl (
        .clk(clk), .rst(rst), .src_ce(src_ce), .dst_ce(dst_ce), .din(din), .dout(d_zl));

    // Bench model state (post-edge values)
    int m_pos = 0;
    logic [W-1:0] m_zl = '0, m_p1 = '0, m_p2 = '0, m_lq = '0;
    logic [W-1:0] pv_pipe = '0, pv_last = '0, pv_zl = '0;
    bit pv_ok = 0;
    bit pv_tail = 0;
    bit after_rst = 0;
    int g_c = 0;
    int g_n = 0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] exp_zl(input logic s, input logic [W-1:0] v);
        return (s && m_pos == 0) ? v : m_zl;
    endfunction

    // Called 1 time unit after the negedge drive; checks then advances the model.
    task automatic tick();
        logic first;
        #1;
        first = src_ce && (m_pos == 0);
        if (!rst) begin
            chk("R1", d_pipe, m_p2);
            chk("R2", d_last, m_lq);
            chk("R3", d_zl, exp_zl(src_ce, din));
            if (after_rst) begin
                chk("R6", d_pipe, '0);
                chk("R6", d_last, '0);
            end
            if (pv_ok) begin
                if (d_pipe !== pv_pipe && !pv_tail) chk("R5", d_pipe, pv_pipe);
                if (d_last !== pv_last && !pv_tail) chk("R5", d_last, pv_last);
                if (d_zl !== pv_zl && !first) chk("R5", d_zl, pv_zl);
            end
            if (use_gen) begin
                logic es, ed;
                es = ((g_c % (int'(gap) + 1)) == 0);
                ed = es && ((g_n % L) == L - 1);
                chk("R8", {15'd0, g_src}, {15'd0, es});
                chk("R8", {15'd0, g_dst}, {15'd0, ed});
            end
        end
        // advance model
        if (rst) begin
            m_pos = 0; m_zl = '0; m_p1 = '0; m_p2 = '0; m_lq = '0;
            pv_ok = 0; pv_tail = 0; after_rst = 1; g_c = 0; g_n = 0;
        end else begin
            pv_pipe = d_pipe; pv_last = d_last; pv_zl = d_zl;
            pv_ok = 1; after_rst = 0;
            pv_tail = src_ce && dst_ce;
            if (use_gen) begin
                g_c++;
                if (g_src) g_n++;
            end
            if (src_ce) begin
                if (m_pos == 0) begin
                    m_zl = din;
                    m_p1 = din;
                end
                if (dst_ce) begin
                    m_p2 = m_p1;
                    m_lq = din;
                    m_pos = 0;
                end else begin
                    m_pos++;
                end
            end
        end
    endtask

    task automatic drive(input logic s, input logic d, input logic [W-1:0] v);
        @(negedge clk);
        b_src = s; b_dst = d; din = v;
        tick();
    endtask

    // Accept one sample, closing the frame when the model says so.
    task automatic sample(input logic [W-1:0] v);
        drive(1'b1, (m_pos == L - 1), v);
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst = 1'b1; b_src = 1'b0; b_dst = 1'b0;
            tick();
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R6: reset state, idle cycles with changing din
        do_reset(3);
        tick();
        drive(1'b0, 1'b0, 16'hBEEF);
        chk("R6", d_zl, '0);

        // R1 R2 R3 R4: back-to-back frames with a known sequence
        for (int i = 0; i < 3 * L; i++) sample(16'h0100 + 16'(i));
        drive(1'b0, 1'b0, 16'h0000);
        chk("R1", d_pipe, 16'h0100 + 16'(2 * L));
        chk("R2", d_last, 16'h0100 + 16'(3 * L - 1));
        chk("R3", d_zl, 16'h0100 + 16'(2 * L));

        // R7: lone dst_ce and idle din inside a frame
        sample(16'h0AAA);
        drive(1'b0, 1'b1, 16'h0BAD);
        drive(1'b0, 1'b0, 16'h0BAE);
        for (int i = 1; i < L; i++) sample(16'h0A00 + 16'(i));
        drive(1'b0, 1'b0, 16'h0000);
        chk("R7", d_pipe, 16'h0AAA);
        chk("R7", d_last, 16'h0A00 + 16'(L - 1));

        // Random spaced stream with stray dst_ce pulses
        for (int i = 0; i < 3000; i++) begin
            logic s, d;
            s = ($urandom_range(99) < 60);
            d = s ? (m_pos == L - 1) : ($urandom_range(49) == 0);
            drive(s, d, W'($urandom));
            if (i == 1500) begin
                // R6: reset in the middle of a frame
                while (m_pos == 0) sample(W'($urandom));
                do_reset(2);
                tick();
            end
        end

        // R8: generator-driven phases
        for (int ph = 0; ph < 2; ph++) begin
            gap = (ph == 0) ? 4'd0 : 4'd2;
            use_gen = 1'b1;
            do_reset(2);
            tick();
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                din = W'($urandom);
                tick();
            end
            use_gen = 1'b0;
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule